// File: doc/BRIEF.md
# Two-Zone Security Firewall

This block stands between the bus initiators of a subsystem and a set of targets, and decides for every request whether it may reach its target. Each target belongs to one of two zones. A secure-zone target takes only secure requests. A non-secure-zone target takes any request. A request that is refused is consumed at the request port and never reaches the target side. One cycle later the initiator receives an error pulse that carries the request's ID.

The security marking of a request is resolved per initiator. An initiator either supplies the marking itself on every request, or has it forced by a policy loaded from a system-management input. The policy has a reset default that is set by parameters.

Zone assignments live in a small register bank reached through a simple register port. Only secure accesses may use that port. The bank also records the most recent refusal in a sticky violation record.

Top module: `secure_fw`

## Requirements
- R1: A request whose effective marking is non-secure and whose target is in the secure zone (zone bit 0) is refused: `fwd_valid` stays 0 and `req_ready` is 1.
- R2: A request to a non-secure-zone target (zone bit 1) is forwarded whatever its marking, with target, ID and payload unchanged and `req_ready` equal to `fwd_ready`. A secure request is forwarded to any target.
- R3: After reset every zone bit is 0 (all targets secure), the violation record is clear and `err_valid` is 0.
- R4: A secure write to register address 0 loads the zone bits: bit t set puts target t in the non-secure zone. A secure read of address 0 returns them.
- R5: A register access with `reg_secure`=0 returns `rsp_err`=1 and `rsp_rdata`=0, and its write changes no register.
- R6: Initiator i's effective marking is policy bit `sec[i]` when policy bit `force[i]` is 1, and otherwise `req_sec`. Both policy vectors load from `sys_cfg_force`/`sys_cfg_sec` on a cycle with `sys_cfg_we`=1. They reset to `INIT_FORCE_RST`/`INIT_SEC_RST`.
- R7: The cycle after a refused handshake, `err_valid` is 1 for one cycle and `err_id` equals the refused request's ID. `err_valid` is 0 in every other cycle.
- R8: Register address 1 holds the violation record. Bit 0 is a sticky flag, bits [15:8] hold the initiator index of the most recent refusal and bits [23:16] its target index. A secure write with bit 0 = 1 clears the record; a refusal in the same cycle wins.
- R9: A request whose `req_tgt` is not exactly one-hot is refused, whatever its marking.
- R10: Every register access is answered one cycle later with `rsp_valid`=1. A secure access to address 2 or 3 returns `rsp_err`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sys_cfg_we | input | 1 | Load the initiator policy vectors |
| sys_cfg_force | input | N_INIT | Per-initiator force-marking enables |
| sys_cfg_sec | input | N_INIT | Per-initiator forced marking (1 = secure) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted |
| req_init | input | IW | Initiator index of the request |
| req_sec | input | 1 | Per-request marking (1 = secure) |
| req_tgt | input | N_TGT | One-hot target select |
| req_id | input | IDW | Transaction ID |
| req_payload | input | PW | Request payload |
| fwd_valid | output | 1 | Forwarded request valid |
| fwd_ready | input | 1 | Target side ready |
| fwd_tgt | output | N_TGT | Forwarded target select |
| fwd_id | output | IDW | Forwarded ID |
| fwd_payload | output | PW | Forwarded payload |
| err_valid | output | 1 | Error response pulse |
| err_id | output | IDW | ID of the refused request |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_secure | input | 1 | Marking of the register access |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Register response valid |
| rsp_err | output | 1 | Register response error |
| rsp_rdata | output | 32 | Register read data |

## Verification
A stuck or wrong zone bit shows up at the very next request to that target. `fwd_valid` takes the wrong value in the same cycle, and `err_valid` appears or stays missing one cycle later. A corrupt initiator policy has the same kind of effect, but only on requests from that initiator. A wrong violation record stays hidden until the next secure read of address 1, which answers one cycle after the access. The bench therefore reads the record back right after each group of refusals and right after a clear.

// File: rtl/fw_pkg.sv
package fw_pkg;
    localparam int REG_W = 32;

    typedef enum logic [1:0] {
        ADDR_ZONE  = 2'd0,
        ADDR_VIOL  = 2'd1,
        ADDR_RSV2  = 2'd2,
        ADDR_RSV3  = 2'd3
    } reg_addr_e;

    localparam int VIOL_FLAG_BIT = 0;
    localparam int VIOL_INIT_LSB = 8;
    localparam int VIOL_TGT_LSB  = 16;
endpackage

// File: rtl/fw_attr.sv
module fw_attr #(
    parameter int               N_INIT         = 4,
    parameter logic [N_INIT-1:0] INIT_FORCE_RST = '0,
    parameter logic [N_INIT-1:0] INIT_SEC_RST   = '0,
    localparam int              IW             = (N_INIT > 1) ? $clog2(N_INIT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [N_INIT-1:0] cfg_force,
    input  logic [N_INIT-1:0] cfg_sec,
    input  logic [IW-1:0]     init_idx,
    input  logic              txn_sec,
    output logic              eff_sec
);
    typedef struct packed {
        logic [N_INIT-1:0] force_en;
        logic [N_INIT-1:0] sec;
    } pol_t;

    pol_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            st_d.force_en = cfg_force;
            st_d.sec      = cfg_sec;
        end
        eff_sec = st_q.force_en[init_idx] ? st_q.sec[init_idx] : txn_sec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.force_en <= INIT_FORCE_RST;
            st_q.sec      <= INIT_SEC_RST;
        end else begin
            st_q <= st_d;
        end
    end

    a_r6_policy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(st_q));
    a_r6_policy_load: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (st_q.force_en == $past(cfg_force)) && (st_q.sec == $past(cfg_sec)));
endmodule

// File: rtl/fw_gate.sv
module fw_gate #(
    parameter int N_INIT = 4,
    parameter int N_TGT  = 8,
    parameter int IDW    = 4,
    parameter int PW     = 32,
    localparam int IW    = (N_INIT > 1) ? $clog2(N_INIT) : 1,
    localparam int TW    = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [IW-1:0]    req_init,
    input  logic             eff_sec,
    input  logic [N_TGT-1:0] req_tgt,
    input  logic [IDW-1:0]   req_id,
    input  logic [PW-1:0]    req_payload,
    input  logic [N_TGT-1:0] zone_ns,
    output logic             fwd_valid,
    input  logic             fwd_ready,
    output logic [N_TGT-1:0] fwd_tgt,
    output logic [IDW-1:0]   fwd_id,
    output logic [PW-1:0]    fwd_payload,
    output logic             err_valid,
    output logic [IDW-1:0]   err_id,
    output logic             deny_pulse,
    output logic [IW-1:0]    deny_init,
    output logic [TW-1:0]    deny_tgt
);
    typedef struct packed {
        logic           err_valid;
        logic [IDW-1:0] err_id;
    } gst_t;

    gst_t st_d, st_q;
    logic one_hot, allow;
    logic [TW-1:0] tgt_enc;

    always_comb begin
        tgt_enc = '0;
        for (int t = N_TGT - 1; t >= 0; t--) begin
            if (req_tgt[t]) tgt_enc = TW'(t);
        end
    end

    always_comb begin
        one_hot = (req_tgt != '0) && ((req_tgt & (req_tgt - 1'b1)) == '0);
        allow   = one_hot && (eff_sec || ((req_tgt & zone_ns) != '0));

        fwd_valid   = req_valid && allow;
        fwd_tgt     = req_tgt;
        fwd_id      = req_id;
        fwd_payload = req_payload;
        req_ready   = allow ? fwd_ready : 1'b1;

        deny_pulse  = req_valid && !allow;
        deny_init   = req_init;
        deny_tgt    = tgt_enc;

        st_d.err_valid = deny_pulse;
        st_d.err_id    = deny_pulse ? req_id : st_q.err_id;

        err_valid = st_q.err_valid;
        err_id    = st_q.err_id;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r7_err_after_deny: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !fwd_valid) |=> (err_valid && err_id == $past(req_id)));
    a_r7_err_only_on_deny: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && fwd_valid) || !req_valid |=> !err_valid);
    a_r9_multi_hot_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !$onehot(req_tgt)) |-> !fwd_valid);
    a_r2_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> (req_ready == fwd_ready));
endmodule

// File: rtl/fw_scr.sv
module fw_scr
    import fw_pkg::*;
#(
    parameter int N_INIT = 4,
    parameter int N_TGT  = 8,
    localparam int IW    = (N_INIT > 1) ? $clog2(N_INIT) : 1,
    localparam int TW    = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_valid,
    input  logic             reg_write,
    input  logic             reg_secure,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic             rsp_valid,
    output logic             rsp_err,
    output logic [REG_W-1:0] rsp_rdata,
    input  logic             deny_pulse,
    input  logic [IW-1:0]    deny_init,
    input  logic [TW-1:0]    deny_tgt,
    output logic [N_TGT-1:0] zone_ns
);
    typedef struct packed {
        logic [N_TGT-1:0] zone;
        logic             vflag;
        logic [IW-1:0]    vinit;
        logic [TW-1:0]    vtgt;
        logic             rvalid;
        logic             rerr;
        logic [REG_W-1:0] rdata;
    } sst_t;

    sst_t st_d, st_q;
    logic sec_acc, mapped, viol_clr;
    logic [REG_W-1:0] rd_mux;

    always_comb begin
        st_d     = st_q;
        sec_acc  = reg_valid && reg_secure;
        mapped   = (reg_addr == ADDR_ZONE) || (reg_addr == ADDR_VIOL);
        viol_clr = sec_acc && reg_write && (reg_addr == ADDR_VIOL) && reg_wdata[VIOL_FLAG_BIT];

        rd_mux = '0;
        if (reg_addr == ADDR_ZONE) begin
            rd_mux[N_TGT-1:0] = st_q.zone;
        end else if (reg_addr == ADDR_VIOL) begin
            rd_mux[VIOL_FLAG_BIT]        = st_q.vflag;
            rd_mux[VIOL_INIT_LSB +: IW]  = st_q.vinit;
            rd_mux[VIOL_TGT_LSB +: TW]   = st_q.vtgt;
        end

        if (sec_acc && reg_write && reg_addr == ADDR_ZONE) begin
            st_d.zone = reg_wdata[N_TGT-1:0];
        end

        if (viol_clr) begin
            st_d.vflag = 1'b0;
            st_d.vinit = '0;
            st_d.vtgt  = '0;
        end
        if (deny_pulse) begin
            st_d.vflag = 1'b1;
            st_d.vinit = deny_init;
            st_d.vtgt  = deny_tgt;
        end

        st_d.rvalid = reg_valid;
        st_d.rerr   = reg_valid && !(reg_secure && mapped);
        st_d.rdata  = (sec_acc && mapped && !reg_write) ? rd_mux : '0;

        rsp_valid = st_q.rvalid;
        rsp_err   = st_q.rerr;
        rsp_rdata = st_q.rdata;
        zone_ns   = st_q.zone;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r5_ns_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && !reg_secure && !deny_pulse) |=> ($stable(st_q.zone) && $stable(st_q.vflag)));
    a_r5_ns_error: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && !reg_secure) |=> (rsp_valid && rsp_err && rsp_rdata == '0));
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vflag && !viol_clr) |=> st_q.vflag);
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        deny_pulse |=> st_q.vflag);
    a_r10_rsp_timing: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(reg_valid));
endmodule

// File: rtl/secure_fw.sv
module secure_fw
    import fw_pkg::*;
#(
    parameter int               N_INIT         = 4,
    parameter int               N_TGT          = 8,
    parameter int               IDW            = 4,
    parameter int               PW             = 32,
    parameter logic [N_INIT-1:0] INIT_FORCE_RST = 4'b0001,
    parameter logic [N_INIT-1:0] INIT_SEC_RST   = 4'b0011,
    localparam int              IW             = (N_INIT > 1) ? $clog2(N_INIT) : 1,
    localparam int              TW             = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_cfg_we,
    input  logic [N_INIT-1:0] sys_cfg_force,
    input  logic [N_INIT-1:0] sys_cfg_sec,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [IW-1:0]     req_init,
    input  logic              req_sec,
    input  logic [N_TGT-1:0]  req_tgt,
    input  logic [IDW-1:0]    req_id,
    input  logic [PW-1:0]     req_payload,
    output logic              fwd_valid,
    input  logic              fwd_ready,
    output logic [N_TGT-1:0]  fwd_tgt,
    output logic [IDW-1:0]    fwd_id,
    output logic [PW-1:0]     fwd_payload,
    output logic              err_valid,
    output logic [IDW-1:0]    err_id,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic              reg_secure,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [REG_W-1:0]  rsp_rdata
);
    logic             eff_sec;
    logic [N_TGT-1:0] zone_ns;
    logic             deny_pulse;
    logic [IW-1:0]    deny_init;
    logic [TW-1:0]    deny_tgt;

    fw_attr #(
        .N_INIT(N_INIT), .INIT_FORCE_RST(INIT_FORCE_RST), .INIT_SEC_RST(INIT_SEC_RST)
    ) u_attr (
        .clk(clk), .rst_n(rst_n), .cfg_we(sys_cfg_we), .cfg_force(sys_cfg_force),
        .cfg_sec(sys_cfg_sec), .init_idx(req_init), .txn_sec(req_sec), .eff_sec(eff_sec)
    );

    fw_gate #(.N_INIT(N_INIT), .N_TGT(N_TGT), .IDW(IDW), .PW(PW)) u_gate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_init(req_init), .eff_sec(eff_sec), .req_tgt(req_tgt), .req_id(req_id),
        .req_payload(req_payload), .zone_ns(zone_ns), .fwd_valid(fwd_valid),
        .fwd_ready(fwd_ready), .fwd_tgt(fwd_tgt), .fwd_id(fwd_id),
        .fwd_payload(fwd_payload), .err_valid(err_valid), .err_id(err_id),
        .deny_pulse(deny_pulse), .deny_init(deny_init), .deny_tgt(deny_tgt)
    );

    fw_scr #(.N_INIT(N_INIT), .N_TGT(N_TGT)) u_scr (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_secure(reg_secure), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .deny_pulse(deny_pulse), .deny_init(deny_init), .deny_tgt(deny_tgt),
        .zone_ns(zone_ns)
    );

    a_r3_all_secure_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (zone_ns == '0));
endmodule

// File: tb/test_secure_fw.sv
module test_secure_fw;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 9;
    // vector: {init[1:0], sec, tgt[7:0], expect_allow}
    localparam logic [11:0] VEC [NV] = '{
        {2'd0, 1'b0, 8'h01, 1'b1},  // R6 forced secure initiator 0
        {2'd1, 1'b0, 8'h01, 1'b0},  // R1
        {2'd1, 1'b1, 8'h00, 1'b0},  // R9 zero-hot
        {2'd1, 1'b1, 8'h03, 1'b0},  // R9 two-hot
        {2'd1, 1'b1, 8'h01, 1'b1},  // R2 secure to secure target
        {2'd2, 1'b0, 8'h20, 1'b1},  // R2 ns to ns target
        {2'd3, 1'b0, 8'h80, 1'b1},  // R2
        {2'd2, 1'b1, 8'h08, 1'b1},  // R2
        {2'd3, 1'b0, 8'h40, 1'b0}   // R1
    };

    logic clk = 0, rst_n = 0;
    logic sys_cfg_we = 0;
    logic [3:0] sys_cfg_force = 0, sys_cfg_sec = 0;
    logic req_valid = 0, req_ready, req_sec = 0, fwd_valid, fwd_ready = 1, err_valid;
    logic [1:0] req_init = 0;
    logic [7:0] req_tgt = 0, fwd_tgt;
    logic [3:0] req_id = 0, fwd_id, err_id;
    logic [31:0] req_payload = 0, fwd_payload;
    logic reg_valid = 0, reg_write = 0, reg_secure = 0, rsp_valid, rsp_err;
    logic [1:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, rsp_rdata;
    int errs = 0, checks = 0;
    logic r_err;
    logic [31:0] r_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    secure_fw i_secure_fw (
        .clk, .rst_n, .sys_cfg_we, .sys_cfg_force, .sys_cfg_sec,
        .req_valid, .req_ready, .req_init, .req_sec, .req_tgt, .req_id, .req_payload,
        .fwd_valid, .fwd_ready, .fwd_tgt, .fwd_id, .fwd_payload, .err_valid, .err_id,
        .reg_valid, .reg_write, .reg_secure, .reg_addr, .reg_wdata,
        .rsp_valid, .rsp_err, .rsp_rdata
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_acc(input logic w, input logic s, input logic [1:0] a,
                           input logic [31:0] d, output logic e, output logic [31:0] rd);
        @(negedge clk);
        reg_valid = 1; reg_write = w; reg_secure = s; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        check("R10 rsp_valid", {31'd0, rsp_valid}, 32'd1);
        e = rsp_err; rd = rsp_rdata;
        reg_valid = 0; reg_write = 0;
    endtask

    task automatic send(input logic [1:0] ini, input logic s, input logic [7:0] t,
                        input logic [3:0] id, input logic exp_allow, input string tag);
        @(negedge clk);
        req_valid = 1; req_init = ini; req_sec = s; req_tgt = t; req_id = id;
        req_payload = {28'hABCDE00, id};
        #1;
        check({tag, " fwd_valid"}, {31'd0, fwd_valid}, {31'd0, exp_allow});
        check({tag, " req_ready"}, {31'd0, req_ready}, {31'd0, (exp_allow ? fwd_ready : 1'b1)});
        if (exp_allow) check({tag, " fwd_payload"}, fwd_payload, {28'hABCDE00, id});
        @(negedge clk);
        req_valid = 0;
        check({tag, " R7 err_valid"}, {31'd0, err_valid}, {31'd0, ~exp_allow});
        if (!exp_allow) check({tag, " R7 err_id"}, {28'd0, err_id}, {28'd0, id});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errs++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R3 reset state
        check("R3 err_valid", {31'd0, err_valid}, 32'd0);
        reg_acc(0, 1, 2'd0, 0, r_err, r_data);
        check("R3 zone all secure", r_data, 32'd0);
        check("R3 rsp_err", {31'd0, r_err}, 32'd0);
        reg_acc(0, 1, 2'd1, 0, r_err, r_data);
        check("R3 violation clear", r_data, 32'd0);

        // R6 reset policy: init0 forced secure, init2 uses its own marking
        send(2'd0, 1'b0, 8'h01, 4'd1, 1'b1, "R6 rst force");
        send(2'd2, 1'b0, 8'h01, 4'd2, 1'b0, "R6 rst own");

        // R4 program zone: targets 5 and 7 non-secure
        reg_acc(1, 1, 2'd0, 32'h0000_00A0, r_err, r_data);
        check("R4 write err", {31'd0, r_err}, 32'd0);
        reg_acc(0, 1, 2'd0, 0, r_err, r_data);
        check("R4 readback", r_data, 32'h0000_00A0);

        // R5 non-secure write and read
        reg_acc(1, 0, 2'd0, 32'hFF, r_err, r_data);
        check("R5 ns err", {31'd0, r_err}, 32'd1);
        check("R5 ns rdata", r_data, 32'd0);
        reg_acc(0, 0, 2'd1, 0, r_err, r_data);
        check("R5 ns read err", {31'd0, r_err}, 32'd1);
        check("R5 ns read rdata", r_data, 32'd0);
        reg_acc(0, 1, 2'd0, 0, r_err, r_data);
        check("R5 zone unchanged", r_data, 32'h0000_00A0);

        // table walk (R1 R2 R7 R9)
        for (int v = 0; v < NV; v++) begin
            send(VEC[v][11:10], VEC[v][9], VEC[v][8:1], 4'(v), VEC[v][0], "table");
        end

        // R8 most recent refusal: init 3, target 6
        reg_acc(0, 1, 2'd1, 0, r_err, r_data);
        check("R8 record", r_data, 32'h0006_0301);
        reg_acc(1, 1, 2'd1, 32'd1, r_err, r_data);
        reg_acc(0, 1, 2'd1, 0, r_err, r_data);
        check("R8 cleared", r_data, 32'd0);

        // R10 unmapped secure access
        reg_acc(0, 1, 2'd2, 0, r_err, r_data);
        check("R10 unmapped err", {31'd0, r_err}, 32'd1);

        // R6 policy reload: init1 forced non-secure, init0 no longer forced
        @(negedge clk);
        sys_cfg_we = 1; sys_cfg_force = 4'b0010; sys_cfg_sec = 4'b0000;
        @(negedge clk);
        sys_cfg_we = 0; sys_cfg_force = 4'b1111; sys_cfg_sec = 4'b1111;
        send(2'd1, 1'b1, 8'h01, 4'd10, 1'b0, "R6 forced ns");
        send(2'd0, 1'b0, 8'h01, 4'd11, 1'b0, "R6 unforced ns");
        send(2'd0, 1'b1, 8'h01, 4'd12, 1'b1, "R6 unforced s");

        // R2 backpressure from target side
        fwd_ready = 0;
        send(2'd2, 1'b0, 8'h20, 4'd13, 1'b1, "R2 backpressure");
        fwd_ready = 1;

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule